// File: doc/BRIEF.md
# Cascaded Decade One-Hot Sequencer

This block chains several ten-state one-hot counters into a single long chaser sequence. Exactly one output bit is lit at a time. Each qualified step moves the lit bit one place up the output vector, and after the top position it wraps back to position zero. Only one stage counts at any moment.

The first stage keeps its terminal state Q9 for control, so it offers nine visible positions (Q0 to Q8). Every later stage also hides its home state Q0, so it offers eight (Q1 to Q8). The full sequence therefore has `9 + 8*(STAGES-1)` positions.

The design is synchronous, with one clock. A step is qualified by a one-cycle enable rather than by a gated clock. Stage clears are synchronous and come from the previous stage's home state or from the wrap condition.

Top module: `cascaded_decade_seq`

## Requirements
- R1: A low `rst_n` at a rising clock edge makes `pos_oh` equal to 1 after that edge (bit 0 high, all others low).
- R2: A cycle with `step` low leaves `pos_oh` unchanged.
- R3: A cycle with `step` high, when bit p of `pos_oh` is set and p is not the top index, makes bit p+1 the only set bit after that edge.
- R4: After reset, `pos_oh` always has exactly one bit set. Its width is `8*STAGES+1`.
- R5: The hand-off from the first stage to the second costs no extra step: one step moves bit 8 to bit 9.
- R6: The hand-off between two later stages costs no extra step: one step moves bit 8k to bit 8k+1, for k from 2 to STAGES-1.
- R7: One step at the top index `8*STAGES` returns `pos_oh` to 1. The last stage never shows or holds its terminal state, so the period is exactly `8*STAGES+1` steps.
- R8: A reset in the middle of the sequence, from any position other than 0, returns `pos_oh` to 1 on the same edge, whatever `step` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | Advance enable, sampled on each rising edge |
| pos_oh | output | 8*STAGES+1 | One-hot sequence position, bit 0 is the start |

## Verification
Long random runs of `step` are checked position by position against a modulo counter in the bench. These runs show whether the lit bit tracks the number of steps, or whether a stage swallows a step or skips one. Directed walks stop on the stage borders (bits 8, 16 and the top bit) to separate a correct same-step hand-off from one that needs a dead step, and to catch a wrap that shows the last terminal state. Runs of idle cycles and random mid-sequence resets tell holding apart from drifting, and show whether reset acts from any position.

// File: rtl/dseq_pkg.sv
// Shared constants and types for the cascaded decade sequencer.
// Assumes each stage is a ten-state one-hot ring with home Q0 and terminal Q9.
package dseq_pkg;
    localparam int DEC_STATES = 10;
    localparam int DEC_HOME   = 0;
    localparam int DEC_TERM   = DEC_STATES - 1;
    localparam int DEC_PRE    = DEC_TERM - 1;
    localparam int HEAD_VIS   = DEC_TERM;      // Q0..Q8 visible on the first stage
    localparam int TAIL_VIS   = DEC_TERM - 1;  // Q1..Q8 visible on later stages

    typedef logic [DEC_STATES-1:0] dec_t;

    localparam dec_t DEC_RESET = dec_t'(1);

    // Number of visible sequence positions for a given stage count
    function automatic int vis_width(input int stages);
        return HEAD_VIS + TAIL_VIS * (stages - 1);
    endfunction
endpackage

// File: rtl/dseq_stage.sv
// One decade stage: a ten-state one-hot ring that halts at its terminal state.
// Assumes clr and adv are single-cycle qualifiers in the clk domain; clr wins.
module dseq_stage
    import dseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output dec_t st,
    output logic arrive
);
    logic moving;

    // Step only when qualified and not already parked at the terminal state
    always_comb begin
        moving = adv && !st[DEC_TERM];
        arrive = moving && st[DEC_PRE];
    end

    // State ring: reset or clear to home, else rotate one place on a step
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st <= DEC_RESET;
        end else if (moving) begin
            st <= {st[DEC_STATES-2:0], st[DEC_TERM]};
        end
    end
endmodule

// File: rtl/dseq_link.sv
// Hand-off logic feeding a non-first stage from its predecessor.
// Assumes the predecessor's arrive flag marks the step that enters its Q9.
module dseq_link
    import dseq_pkg::*;
(
    input  logic step,
    input  dec_t prev_st,
    input  logic prev_arrive,
    input  logic wrap,
    output logic adv,
    output logic clr
);
    // Gate the step by the predecessor parked at, or entering, its terminal state
    always_comb begin
        adv = step && (prev_st[DEC_TERM] || prev_arrive);
    end

    // Hold this stage at home while the predecessor is home, or on a wrap
    always_comb begin
        clr = wrap || prev_st[DEC_HOME];
    end
endmodule

// File: rtl/dseq_map.sv
// Maps stage states onto the flat one-hot position vector.
// Assumes stage 0 exposes Q0..Q8 and each later stage exposes Q1..Q8.
module dseq_map
    import dseq_pkg::*;
#(
    parameter int STAGES = 3,
    localparam int VIS = vis_width(STAGES)
) (
    input  logic [STAGES*DEC_STATES-1:0] st_flat,
    output logic [VIS-1:0]               pos_oh
);
    genvar k, j;
    generate
        for (j = 0; j < HEAD_VIS; j++) begin : g_head
            assign pos_oh[j] = st_flat[j];
        end
        for (k = 1; k < STAGES; k++) begin : g_tail
            for (j = 1; j <= TAIL_VIS; j++) begin : g_bit
                assign pos_oh[HEAD_VIS + TAIL_VIS*(k-1) + j - 1] = st_flat[k*DEC_STATES + j];
            end
        end
    endgenerate
endmodule

// File: rtl/cascaded_decade_seq.sv
// Top: chains STAGES decade stages into one one-hot chaser of 8*STAGES+1 positions.
// Assumes STAGES >= 2; fully synchronous, active-low synchronous reset.
module cascaded_decade_seq
    import dseq_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [8*STAGES:0]   pos_oh
);
    localparam int VIS = vis_width(STAGES);

    dec_t                          st    [STAGES];
    logic [STAGES-1:0]             adv;
    logic [STAGES-1:0]             clr;
    logic [STAGES-1:0]             arrive;
    logic [STAGES*DEC_STATES-1:0]  st_flat;
    logic                          wrap;

    // Wrap on the step that would carry the last stage into its terminal state
    always_comb begin
        wrap = arrive[STAGES-1];
    end

    // The first stage counts on every step and is cleared only on a wrap
    always_comb begin
        adv[0] = step;
        clr[0] = wrap;
    end

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            if (k > 0) begin : g_link
                dseq_link u_link (
                    .step        (step),
                    .prev_st     (st[k-1]),
                    .prev_arrive (arrive[k-1]),
                    .wrap        (wrap),
                    .adv         (adv[k]),
                    .clr         (clr[k])
                );
            end
            dseq_stage u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (clr[k]),
                .adv    (adv[k]),
                .st     (st[k]),
                .arrive (arrive[k])
            );
            assign st_flat[k*DEC_STATES +: DEC_STATES] = st[k];
        end
    endgenerate

    logic [VIS-1:0] vis;

    dseq_map #(.STAGES(STAGES)) u_map (
        .st_flat (st_flat),
        .pos_oh  (vis)
    );

    assign pos_oh = vis;
endmodule

// File: rtl/dseq_chk.sv
// Checker for cascaded_decade_seq, attached by bind; observes ports and stage states.
// Assumes the STAGES parameter matches the bound instance.
module dseq_chk
    import dseq_pkg::*;
#(
    parameter int STAGES = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         step,
    input logic [8*STAGES:0]            pos_oh,
    input logic [STAGES*DEC_STATES-1:0] st_flat
);
    localparam int TOP = 8*STAGES;

    AST_RESET_HOME: assert property (@(posedge clk) !rst_n |=> (pos_oh == (TOP+1)'(1))); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !step |=> $stable(pos_oh)); // R2
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) (step && !pos_oh[TOP]) |=> (pos_oh == ($past(pos_oh) << 1))); // R3
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(pos_oh) == 1); // R4
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (step && pos_oh[TOP]) |=> (pos_oh == (TOP+1)'(1))); // R7
    AST_NO_LAST_TERM: assert property (@(posedge clk) disable iff (!rst_n) !st_flat[(STAGES-1)*DEC_STATES + DEC_TERM]); // R7

    genvar k;
    generate
        for (k = 1; k < STAGES; k++) begin : g_tail
            AST_TAIL_HOME: assert property (@(posedge clk) disable iff (!rst_n) st_flat[(k-1)*DEC_STATES] |-> st_flat[k*DEC_STATES]); // R4
        end
    endgenerate
endmodule

bind cascaded_decade_seq dseq_chk #(.STAGES(STAGES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .pos_oh  (pos_oh),
    .st_flat (st_flat)
);

// File: tb/tb_cascaded_decade_seq.sv
module tb_cascaded_decade_seq;
    localparam int STAGES = 3;
    localparam int L      = 8*STAGES + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step = 1'b0;
    logic [L-1:0] pos_oh;

    int checks = 0;
    int errors = 0;
    int pos    = 0;
    bit done   = 1'b0;

    cascaded_decade_seq #(.STAGES(STAGES)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .pos_oh (pos_oh)
    );

    always #5 clk = ~clk;

    function automatic logic [L-1:0] expect_vec(input int p);
        return (L)'(1) << p;
    endfunction

    function automatic string tag_for(input bit s, input bit r, input int p);
        if (!r) return (p != 0) ? "R8" : "R1";
        if (!s) return "R2";
        if (p == 8) return "R5";
        if (p == L-1) return "R7";
        if (p > 8 && (p % 8) == 0) return "R6";
        return "R3";
    endfunction

    // Apply one cycle of stimulus, advance the model, compare after the edge
    task automatic tick(input bit s, input bit r);
        string tg;
        tg = tag_for(s, r, pos);
        step  = s;
        rst_n = r;
        @(posedge clk);
        #1;
        if (!r) pos = 0;
        else if (s) pos = (pos + 1) % L;
        checks++;
        if (pos_oh !== expect_vec(pos)) begin
            errors++;
            $display("FAIL %s: pos_oh=%h expected=%h", tg, pos_oh, expect_vec(pos));
        end
        checks++;
        if ($countones(pos_oh) != 1) begin
            errors++;
            $display("FAIL R4: ones=%0d expected=1", $countones(pos_oh));
        end
    endtask

    task automatic walk_to(input int target);
        while (pos != target) tick(1'b1, 1'b1);
    endtask

    initial begin
        int seed;
        int r;
        seed = 1234;
        r = $urandom(seed);
        #1;
        tick(1'b0, 1'b0);                           // R1
        tick(1'b1, 1'b0);                           // R1 reset beats step
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b1); // R2 idle at home
        walk_to(8);
        tick(1'b1, 1'b1);                           // R5 hand-off 8 -> 9
        walk_to(16);
        tick(1'b0, 1'b1);                           // R2 idle at a border
        tick(1'b1, 1'b1);                           // R6 hand-off 16 -> 17
        walk_to(L-1);
        tick(1'b0, 1'b1);                           // R2 idle at the top
        tick(1'b1, 1'b1);                           // R7 wrap
        for (int i = 0; i < 2*L; i++) tick(1'b1, 1'b1); // R7 two full periods
        walk_to(13);
        tick(1'b0, 1'b0);                           // R8 mid-sequence reset
        for (int i = 0; i < 3000; i++) begin
            bit s;
            bit rr;
            s  = ($urandom % 4) != 0;
            rr = ($urandom % 97) != 0;
            tick(s, rr);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule